// File: doc/BRIEF.md
# Peripheral Clock-Enable Controller with Aligned Time-Base Start

This block holds one 16-bit control word on a small synchronous bus. The word decides which peripherals receive clock activity. Every output is a one-cycle clock-enable strobe in the system clock domain, and no clock net is ever gated. Some peripherals take the full system rate. One channel takes half that rate. The serial (SCI) and SPI channels take a low-speed rate, which is a programmable divide of the system clock.

The block also drives the time-base ticks of several PWM channels. A single sync bit in the control word stops every time-base divider. When the bit is set again, all enabled channels restart from count zero on the same cycle, so their first time-base ticks line up. A separate per-channel module-enable word arrives on an input. Setting a channel's bit in that word gives the channel its system-clock enable whatever the state of the sync bit.

The block has no data stream, so there is no valid/ready handshake. The bus has no back-pressure: a write takes effect at the clock edge where write enable is sampled. Read data is registered and appears one cycle after the address is presented. The intended start-up order for the PWM channels is:
1. Set their module enables.
2. Clear the sync bit.
3. Load the prescalers.
4. Set the sync bit.

Top module: `periph_clk_ctrl`

## Requirements
- R1: While reset is asserted and right after it, the control word is 0 and every output is 0, including read data, all clock enables and all time-base ticks.
- R2: A write to address 0 stores the write data with bits 15, 13, 7, 6, 5 and 1 forced to 0, so writing 0xFFFF reads back 0x5F1D. A write to any other address leaves the control word unchanged.
- R3: Read data one cycle after an address is presented equals the control word as it stood at that edge when the address is 0, and equals 0 for any other address.
- R4: Bit 12 drives serp_ce, bit 4 drives i2c_ce, bit 3 drives adc_ce and bit 0 drives hrpwm_ce. Each of these enables is high on every system cycle while its bit is 1.
- R5: While bit 14 is 1, can_ce is high on alternate cycles only (never two cycles in a row), giving half the system rate. While bit 14 is 0, can_ce stays low.
- R6: The low-speed tick fires once every lsp_div+1 system cycles. sci_ce[1] and sci_ce[0] follow bits 11 and 10, and spi_ce[1] and spi_ce[0] follow bits 9 and 8. Each of these enables is high only on a low-speed tick while its bit is 1.
- R7: pwm_ce equals pwm_mod_en on every cycle, regardless of the sync bit (bit 2).
- R8: While bit 2 is 0, tb_tick is 0 for every channel.
- R9: On the first cycle in which bit 2 is 1, every channel whose module enable is set ticks on that same cycle.
- R10: After its start tick, a running channel ticks once every psc+1 cycles, where psc is its field of pwm_psc (channel c occupies bits c*PSC_W and up).
- R11: A prescaler change made while a channel runs is adopted at that channel's next tick. The period already in progress keeps its old length and the counter is not reset.
- R12: A channel whose module enable is 0 never ticks, even while bit 2 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address; the control word sits at REG_ADDR (0) |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| lsp_div | input | LSP_DIV_W | Low-speed divider; period is lsp_div+1 cycles |
| pwm_mod_en | input | N_PWM | Per-channel PWM module enable |
| pwm_psc | input | N_PWM*PSC_W | Per-channel time-base prescaler fields |
| can_ce | output | 1 | Half-rate enable for the CAN channel |
| serp_ce | output | 1 | System-rate enable for the serial port |
| sci_ce | output | 2 | Low-speed enables for the two SCI channels |
| spi_ce | output | 2 | Low-speed enables for the two SPI channels |
| i2c_ce | output | 1 | System-rate enable for the I2C channel |
| adc_ce | output | 1 | System-rate enable for the ADC |
| hrpwm_ce | output | 1 | System-rate enable for the high-resolution PWM |
| pwm_ce | output | N_PWM | System-rate enables for the PWM modules |
| tb_tick | output | N_PWM | Time-base tick per PWM channel |

## Verification
The assertions check several properties on every cycle:
- No reserved bit is ever read back as 1.
- Read data tracks the addressed word with one cycle of latency.
- The half-rate enable never fires twice in a row.
- The serial enables appear only on a low-speed tick.
- No time-base tick occurs while sync is clear or for a disabled channel.
- All enabled channels tick together on the first sync cycle.

Other behaviours are shown only by the bench's scenarios, where the cycle-by-cycle model is compared against the design:
- The exact tick spacing for each prescaler.
- The deferred adoption of a prescaler changed mid-run.
- The low-speed period under changing divisors.
- The effect of writes to other addresses.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;
  localparam int CTRL_W = 16;
  // bits that hold state; all others are reserved and always zero
  localparam logic [CTRL_W-1:0] CTRL_WMASK = 16'h5F1D;
  localparam int B_CAN  = 14;
  localparam int B_SERP = 12;
  localparam int B_SCI0 = 10;  // SCI channel 1 at B_SCI0+1
  localparam int B_SPI0 = 8;   // SPI channel 1 at B_SPI0+1
  localparam int B_I2C  = 4;
  localparam int B_ADC  = 3;
  localparam int B_SYNC = 2;
  localparam int B_HRP  = 0;
  localparam int N_LSP_PAIR = 2;
endpackage

// File: rtl/pcc_regs.sv
`timescale 1ns/1ps
module pcc_regs
  import pcc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [CTRL_W-1:0] wdata,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic [CTRL_W-1:0] rdata
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);
  logic hit;
  assign hit = (addr == SEL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rdata  <= '0;
    end else begin
      rdata <= hit ? ctrl_q : '0;
      if (we && hit) ctrl_q <= wdata & CTRL_WMASK;
    end
  end
endmodule

// File: rtl/pcc_rate_gen.sv
`timescale 1ns/1ps
module pcc_rate_gen #(
  parameter int LSP_DIV_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LSP_DIV_W-1:0] lsp_div,
  output logic                 half_tick,
  output logic                 lsp_tick
);
  logic                 half_ph;
  logic [LSP_DIV_W-1:0] lsp_cnt;

  assign half_tick = half_ph;
  // >= so a divisor lowered below the count wraps at once
  assign lsp_tick  = (lsp_cnt >= lsp_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_ph <= 1'b0;
      lsp_cnt <= '0;
    end else begin
      half_ph <= ~half_ph;
      lsp_cnt <= lsp_tick ? '0 : lsp_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pcc_tb_chan.sv
`timescale 1ns/1ps
module pcc_tb_chan #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [PSC_W-1:0] psc,
  output logic             tick
);
  logic             running;
  logic [PSC_W-1:0] cnt;
  logic [PSC_W-1:0] psc_act;

  // first cycle of run_en gives the aligned start tick
  assign tick = run_en & (~running | (cnt == psc_act));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
      psc_act <= '0;
    end else if (!run_en) begin
      running <= 1'b0;
      cnt     <= '0;
      psc_act <= psc;
    end else if (!running) begin
      running <= 1'b1;
      cnt     <= '0;
      psc_act <= psc;
    end else if (cnt == psc_act) begin
      cnt     <= '0;
      psc_act <= psc;
    end else begin
      cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/periph_clk_ctrl.sv
`timescale 1ns/1ps
module periph_clk_ctrl
  import pcc_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int REG_ADDR  = 0,
  parameter int LSP_DIV_W = 4,
  parameter int N_PWM     = 3,
  parameter int PSC_W     = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic                   bus_we,
  input  logic [15:0]            bus_wdata,
  output logic [15:0]            bus_rdata,
  input  logic [LSP_DIV_W-1:0]   lsp_div,
  input  logic [N_PWM-1:0]       pwm_mod_en,
  input  logic [N_PWM*PSC_W-1:0] pwm_psc,
  output logic                   can_ce,
  output logic                   serp_ce,
  output logic [1:0]             sci_ce,
  output logic [1:0]             spi_ce,
  output logic                   i2c_ce,
  output logic                   adc_ce,
  output logic                   hrpwm_ce,
  output logic [N_PWM-1:0]       pwm_ce,
  output logic [N_PWM-1:0]       tb_tick
);
  logic [CTRL_W-1:0] ctrl_q;
  logic              half_tick;
  logic              lsp_tick;
  logic [N_PWM-1:0]  chan_run;
  logic              unused_rsv;

  assign unused_rsv = ^(ctrl_q & ~CTRL_WMASK);

  pcc_regs #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we),
    .wdata(bus_wdata), .ctrl_q(ctrl_q), .rdata(bus_rdata)
  );

  pcc_rate_gen #(.LSP_DIV_W(LSP_DIV_W)) u_rate (
    .clk(clk), .rst_n(rst_n), .lsp_div(lsp_div),
    .half_tick(half_tick), .lsp_tick(lsp_tick)
  );

  assign can_ce   = ctrl_q[B_CAN] & half_tick;
  assign serp_ce  = ctrl_q[B_SERP];
  assign i2c_ce   = ctrl_q[B_I2C];
  assign adc_ce   = ctrl_q[B_ADC];
  assign hrpwm_ce = ctrl_q[B_HRP];
  assign pwm_ce   = pwm_mod_en;

  for (genvar g = 0; g < N_LSP_PAIR; g++) begin : g_lsp
    assign sci_ce[g] = ctrl_q[B_SCI0+g] & lsp_tick;
    assign spi_ce[g] = ctrl_q[B_SPI0+g] & lsp_tick;
  end

  for (genvar c = 0; c < N_PWM; c++) begin : g_chan
    assign chan_run[c] = ctrl_q[B_SYNC] & pwm_mod_en[c];
    pcc_tb_chan #(.PSC_W(PSC_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .run_en(chan_run[c]),
      .psc(pwm_psc[c*PSC_W +: PSC_W]), .tick(tb_tick[c])
    );
  end
endmodule

// File: rtl/pcc_checker.sv
`timescale 1ns/1ps
module pcc_checker
  import pcc_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int REG_ADDR = 0,
  parameter int N_PWM    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [15:0]       bus_rdata,
  input logic [15:0]       ctrl_q,
  input logic              can_ce,
  input logic [1:0]        sci_ce,
  input logic [1:0]        spi_ce,
  input logic              lsp_tick,
  input logic [N_PWM-1:0]  tb_tick,
  input logic [N_PWM-1:0]  pwm_mod_en
);
  localparam logic [ADDR_W-1:0] SEL = ADDR_W'(REG_ADDR);

  a_r2_rsv_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rdata & ~CTRL_WMASK) == 16'h0);

  a_r3_read_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == SEL) |=> (bus_rdata == $past(ctrl_q)));

  a_r3_read_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr != SEL) |=> (bus_rdata == 16'h0));

  a_r5_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    can_ce |=> !can_ce);

  a_r6_on_lsp: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sci_ce) || (|spi_ce)) |-> lsp_tick);

  a_r8_sync_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[B_SYNC] |-> (tb_tick == '0));

  a_r9_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctrl_q[B_SYNC]) |-> (tb_tick == pwm_mod_en));

  a_r12_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (tb_tick & ~pwm_mod_en) == '0);
endmodule

bind periph_clk_ctrl pcc_checker #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .N_PWM(N_PWM)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rdata(bus_rdata),
  .ctrl_q(ctrl_q), .can_ce(can_ce), .sci_ce(sci_ce), .spi_ce(spi_ce),
  .lsp_tick(lsp_tick), .tb_tick(tb_tick), .pwm_mod_en(pwm_mod_en)
);

// File: tb/periph_clk_ctrl_test.sv
`timescale 1ns/1ps
module periph_clk_ctrl_test;
  localparam int CLK_P = 10;
  localparam int AW = 4;
  localparam int LW = 4;
  localparam int NP = 3;
  localparam int PW = 4;
  localparam logic [15:0] MASK = 16'h5F1D;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [LW-1:0] lsp_div = '0;
  logic [NP-1:0] pwm_mod_en = '0;
  logic [NP*PW-1:0] pwm_psc = '0;
  logic can_ce, serp_ce, i2c_ce, adc_ce, hrpwm_ce;
  logic [1:0] sci_ce, spi_ce;
  logic [NP-1:0] pwm_ce, tb_tick;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  periph_clk_ctrl #(.ADDR_W(AW), .REG_ADDR(0), .LSP_DIV_W(LW), .N_PWM(NP), .PSC_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lsp_div(lsp_div),
    .pwm_mod_en(pwm_mod_en), .pwm_psc(pwm_psc), .can_ce(can_ce),
    .serp_ce(serp_ce), .sci_ce(sci_ce), .spi_ce(spi_ce), .i2c_ce(i2c_ce),
    .adc_ce(adc_ce), .hrpwm_ce(hrpwm_ce), .pwm_ce(pwm_ce), .tb_tick(tb_tick)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [15:0] m_ctrl = '0;
  logic [15:0] m_rd = '0;
  bit m_half = 1'b0;
  int m_lcnt = 0;
  int m_run[NP];
  int m_cnt[NP];
  int m_pact[NP];

  function automatic int psc_of(int i);
    return int'(pwm_psc[i*PW +: PW]);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = '0; m_rd = '0; m_half = 0; m_lcnt = 0;
      for (int i = 0; i < NP; i++) begin m_run[i] = 0; m_cnt[i] = 0; m_pact[i] = 0; end
    end else begin
      m_rd = (bus_addr == 0) ? m_ctrl : 16'h0;
      m_half = !m_half;
      m_lcnt = (m_lcnt >= int'(lsp_div)) ? 0 : m_lcnt + 1;
      for (int i = 0; i < NP; i++) begin
        if (!(m_ctrl[2] && pwm_mod_en[i])) begin
          m_run[i] = 0; m_cnt[i] = 0; m_pact[i] = psc_of(i);
        end else if (m_run[i] == 0) begin
          m_run[i] = 1; m_cnt[i] = 0; m_pact[i] = psc_of(i);
        end else if (m_cnt[i] == m_pact[i]) begin
          m_cnt[i] = 0; m_pact[i] = psc_of(i);
        end else m_cnt[i]++;
      end
      if (bus_we && bus_addr == 0) m_ctrl = bus_wdata & MASK;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      logic lt;
      logic [NP-1:0] etb;
      lt = (m_lcnt >= int'(lsp_div));
      for (int i = 0; i < NP; i++)
        etb[i] = m_ctrl[2] && pwm_mod_en[i] && (m_run[i] == 0 || m_cnt[i] == m_pact[i]);
      chk("R2 R3 read data", 32'(bus_rdata), 32'(m_rd));
      chk("R4 system enables", {28'h0, serp_ce, i2c_ce, adc_ce, hrpwm_ce},
          {28'h0, m_ctrl[12], m_ctrl[4], m_ctrl[3], m_ctrl[0]});
      chk("R5 half rate", 32'(can_ce), 32'(m_ctrl[14] & m_half));
      chk("R6 low speed", {28'h0, sci_ce, spi_ce},
          {28'h0, m_ctrl[11] & lt, m_ctrl[10] & lt, m_ctrl[9] & lt, m_ctrl[8] & lt});
      chk("R7 pwm clock", 32'(pwm_ce), 32'(pwm_mod_en));
      chk("R8 R9 R10 R11 R12 time base", 32'(tb_tick), 32'(etb));
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(logic [AW-1:0] a, logic [15:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk);
    @(negedge clk); bus_we = 1'b0; bus_addr = '0;
  endtask

  task automatic rd_chk(logic [AW-1:0] a, logic [15:0] exp, string req);
    @(negedge clk); bus_addr = a;
    @(posedge clk);
    @(negedge clk); chk(req, 32'(bus_rdata), 32'(exp)); bus_addr = '0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R1 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    int cnt0, cnt1, cnt2;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 reset outputs", {bus_rdata, 6'h0, can_ce, serp_ce, sci_ce, spi_ce, i2c_ce, adc_ce, hrpwm_ce, tb_tick},
        32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset", {bus_rdata, 13'h0, tb_tick}, 32'h0);

    // R2: reserved masking and address decode
    wr(0, 16'hFFFF);
    rd_chk(0, 16'h5F1D, "R2 reserved bits read zero");
    wr(3, 16'h0000);
    rd_chk(0, 16'h5F1D, "R2 other address write ignored");
    rd_chk(5, 16'h0000, "R3 other address reads zero");

    // R5: half rate
    wr(0, 16'h4000);
    cnt0 = 0;
    for (int k = 0; k < 10; k++) begin @(negedge clk); cnt0 += int'(can_ce); end
    chk("R5 half rate count", 32'(cnt0), 32'd5);

    // R6: low-speed divider with several divisors
    lsp_div = 4'd3;
    wr(0, 16'h0F00);
    cnt0 = 0;
    for (int k = 0; k < 16; k++) begin @(negedge clk); cnt0 += int'(sci_ce[0]); end
    chk("R6 sci period 4", 32'(cnt0), 32'd4);
    lsp_div = 4'd0; repeat (6) @(negedge clk);
    lsp_div = 4'd6; repeat (20) @(negedge clk);
    lsp_div = 4'd1; repeat (8) @(negedge clk);

    // R4: system-rate enables
    wr(0, 16'h1019);
    chk("R4 system enables on", {28'h0, serp_ce, i2c_ce, adc_ce, hrpwm_ce}, 32'hF);

    // PWM start sequence
    pwm_mod_en = 3'b011;
    wr(0, 16'h0000);
    pwm_psc = {4'd3, 4'd2, 4'd1};
    cnt0 = 0;
    for (int k = 0; k < 8; k++) begin @(negedge clk); cnt0 += int'(tb_tick != 0); end
    chk("R8 no ticks without sync", 32'(cnt0), 32'd0);
    chk("R7 pwm clock while sync clear", 32'(pwm_ce), 32'(3'b011));
    wr(0, 16'h0004);
    chk("R9 aligned start", 32'(tb_tick), 32'(3'b011));
    cnt0 = 0; cnt1 = 0; cnt2 = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      cnt0 += int'(tb_tick[0]); cnt1 += int'(tb_tick[1]); cnt2 += int'(tb_tick[2]);
    end
    chk("R10 channel0 period 2", 32'(cnt0), 32'd6);
    chk("R10 channel1 period 3", 32'(cnt1), 32'd4);
    chk("R12 disabled channel silent", 32'(cnt2), 32'd0);

    // R11: change prescaler mid-run
    @(negedge clk); pwm_psc[PW-1:0] = 4'd4;
    repeat (20) @(negedge clk);
    // enable third channel while running
    pwm_mod_en = 3'b111;
    repeat (12) @(negedge clk);
    // restart with identical prescalers
    wr(0, 16'h0000);
    pwm_psc = {4'd2, 4'd2, 4'd2};
    repeat (3) @(negedge clk);
    wr(0, 16'h0004);
    chk("R9 aligned restart", 32'(tb_tick), 32'(3'b111));
    repeat (15) @(negedge clk);
    wr(0, 16'h0000);
    chk("R8 ticks stop", 32'(tb_tick), 32'd0);
    repeat (4) @(negedge clk);

    summary();
    $finish;
  end
endmodule